// File: doc/BRIEF.md
# Byte-Lane Static RAM Core

This block is a synchronous model of a 16-bit-wide static memory. Its control pins are all active low: a chip select, an output enable, a write enable, and one enable for each byte lane. A small decoder turns the five control pins into one of four modes: standby, outputs off, read or write. Each byte lane then stores or returns its own 8 bits. The data port is split into an input word, an output word and one drive-enable bit per lane. A pad ring or a testbench can rebuild the bidirectional bus from these signals and watch each lane's high-impedance state on its own.

All inputs are sampled on the rising clock edge. A write commits on the edge where it is presented. A read returns the addressed bytes `READ_LAT` edges after the read condition starts, as long as the condition is held for that many edges. This latency stands in for access time. The depth is `2**ADDR_W` words. The full-size part uses `ADDR_W = 16` (65,536 words). The default is smaller so that elaboration stays light. Memory contents are undefined after reset, so every location must be written before it is read.

Top module: `byte_lane_sram`

## Requirements
- R1: The array holds `2**ADDR_W` words of 16 bits. Every address from 0 to `2**ADDR_W-1` keeps its own data independently of the others.
- R2: When `ce_n` is high, or when `lb_n` and `ub_n` are both high, the block is in standby. Both `dout_en` bits are 0 and no byte is written, even if `we_n` is low.
- R3: With `ce_n` low and both `oe_n` and `we_n` high, both `dout_en` bits stay 0 and nothing is written.
- R4: A read needs `ce_n` low, `oe_n` low and `we_n` high. A lane with its enable low raises its `dout_en` bit and presents its stored byte only after that condition has been sampled on `READ_LAT` consecutive rising edges. Before that, the bit stays 0.
- R5: Lane mapping: `lb_n` and `dout_en[0]` govern bits 7:0 of `din`/`dout`. `ub_n` and `dout_en[1]` govern bits 15:8.
- R6: A write happens at a rising edge where `ce_n` and `we_n` are low, whatever the value of `oe_n`. Only lanes with their enable low take `din`. The other lane's stored byte is unchanged.
- R7: While `ce_n` and `we_n` are both low, both `dout_en` bits are 0.
- R8: A lane's `dout_en` bit falls in the same cycle that its read condition is removed, with no clock edge in between.
- R9: A lane whose `dout_en` bit is 0 presents 0 on its eight `dout` bits.
- R10: A rising edge with `rst_n` low clears both `dout_en` bits. After `rst_n` returns high, output needs a fresh `READ_LAT`-edge read before it reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read pipeline |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; has priority over `oe_n` |
| lb_n | input | 1 | Lower byte lane enable (bits 7:0), active low |
| ub_n | input | 1 | Upper byte lane enable (bits 15:8), active low |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data; a lane reads as 0 when it is not driven |
| dout_en | output | 2 | Per-lane drive enable: bit 0 for the lower lane, bit 1 for the upper lane |

## Verification
A wrong word in the array, or a byte written on the wrong lane, stays hidden until that address is read back. It then appears on `dout` `READ_LAT` edges after the read begins, so every write is followed at some point by a read of the same location. A wrong decoder state or a stale pipeline valid bit shows up at once on `dout_en`. It is visible in the cycle the controls change for the write and release cases, or on the edge before data is due for the latency case. The bench samples `dout_en` at those points.

// File: rtl/blsram_pkg.sv
// Package: shared constants and the decoded mode type for the byte-lane RAM.
// Assumes a data word of exactly two byte lanes.
package blsram_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    // Decoded operating mode of the control pins
    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_OUT_OFF = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } mode_e;

endpackage

// File: rtl/blsram_ctrl.sv
// Module: control decoder.
// Turns the active-low control pins into a mode and into per-lane read
// and write strobes. Purely combinational. Write enable has priority over
// output enable, and deselect has priority over everything else.
module blsram_ctrl
    import blsram_pkg::*;
(
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic [LANES-1:0] lane_n,
    output mode_e            mode,
    output logic [LANES-1:0] lane_rd,
    output logic [LANES-1:0] lane_wr
);

    // Priority decode of the pins into one mode
    always_comb begin
        if (ce_n || (&lane_n)) begin
            mode = MODE_STANDBY;
        end else if (!we_n) begin
            mode = MODE_WRITE;
        end else if (!oe_n) begin
            mode = MODE_READ;
        end else begin
            mode = MODE_OUT_OFF;
        end
    end

    // Per-lane strobes: a lane acts only if its own enable is low
    always_comb begin
        lane_rd = (mode == MODE_READ)  ? ~lane_n : '0;
        lane_wr = (mode == MODE_WRITE) ? ~lane_n : '0;
    end

endmodule

// File: rtl/blsram_lane.sv
// Module: one byte lane of storage together with its read pipeline.
// Writes commit at the rising edge where wr is high. A read returns the
// byte at the address sampled READ_LAT edges earlier. The drive enable is
// raised only when rd has been high on READ_LAT consecutive edges and is
// still high now. Assumes READ_LAT >= 1. The storage is not reset.
module blsram_lane #(
    parameter int ADDR_W   = 11,
    parameter int LANE_W   = 8,
    parameter int READ_LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout,
    output logic              dout_en
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] data_q [READ_LAT];
    logic              vld_q  [READ_LAT];

    // Storage write port
    always_ff @(posedge clk) begin
        if (wr) begin
            mem[addr] <= din;
        end
    end

    // First pipeline stage: array read and start of the read-valid chain
    always_ff @(posedge clk) begin
        data_q[0] <= mem[addr];
        if (!rst_n) begin
            vld_q[0] <= 1'b0;
        end else begin
            vld_q[0] <= rd;
        end
    end

    // Further stages: the valid bit survives only while rd stays high
    for (genvar s = 1; s < READ_LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            data_q[s] <= data_q[s-1];
            if (!rst_n) begin
                vld_q[s] <= 1'b0;
            end else begin
                vld_q[s] <= vld_q[s-1] && rd;
            end
        end
    end

    // Output gate: drop the drive in the same cycle the read ends
    always_comb begin
        dout_en = rd && vld_q[READ_LAT-1];
        dout    = dout_en ? data_q[READ_LAT-1] : '0;
    end

    // The lane may only drive if a read was sampled on the previous edge
    p_prior_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(rd));

    // The first edge after a reset edge never leaves the lane driving
    p_reset_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !vld_q[0]);

    // A lane is never written and driven at the same time
    p_no_drive_on_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> !dout_en);

endmodule

// File: rtl/byte_lane_sram.sv
// Module: top level of the byte-lane static RAM.
// Decodes the active-low control pins once and feeds one storage lane per
// byte. Lane 0 is bits 7:0 under lb_n and lane 1 is bits 15:8 under ub_n.
// Assumes the inputs are synchronous to clk. Storage is undefined after
// reset, and only the read pipeline is cleared.
module byte_lane_sram
    import blsram_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int READ_LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [LANES-1:0]  dout_en
);

    mode_e            mode;
    logic [LANES-1:0] lane_n;
    logic [LANES-1:0] lane_rd;
    logic [LANES-1:0] lane_wr;

    // Gather the lane enables, lower lane in bit 0
    always_comb begin
        lane_n = {ub_n, lb_n};
    end

    blsram_ctrl i_ctrl (
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .lane_n  (lane_n),
        .mode    (mode),
        .lane_rd (lane_rd),
        .lane_wr (lane_wr)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        blsram_lane #(
            .ADDR_W   (ADDR_W),
            .LANE_W   (LANE_W),
            .READ_LAT (READ_LAT)
        ) i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .addr    (addr),
            .wr      (lane_wr[g]),
            .rd      (lane_rd[g]),
            .din     (din[g*LANE_W +: LANE_W]),
            .dout    (dout[g*LANE_W +: LANE_W]),
            .dout_en (dout_en[g])
        );

        // An undriven lane shows zero
        p_zero_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !dout_en[g] |-> (dout[g*LANE_W +: LANE_W] == '0));
    end

    // Standby silences both lanes
    p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || (lb_n && ub_n)) |-> (dout_en == '0));

    // Outputs-off mode silences both lanes
    p_out_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && we_n) |-> (dout_en == '0));

    // Lane gating follows its own enable pin
    p_lower_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lb_n |-> !dout_en[0]);
    p_upper_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ub_n |-> !dout_en[1]);

    // Write priority: a write decode never drives, whatever oe_n is
    p_write_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |-> (dout_en == '0));

    // The decoder reports write mode for every write pin pattern
    p_write_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n && !(lb_n && ub_n)) |-> (mode == MODE_WRITE));

    // Drive stops at once when output enable is released
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (dout_en == '0));

endmodule

// File: tb/test_byte_lane_sram.sv
// Bench for byte_lane_sram: a directed fill and corner cases, then seeded
// random operations checked against a bench-side word model.
module test_byte_lane_sram;

    localparam int AW    = 11;
    localparam int RL    = 2;
    localparam int DEPTH = 1 << AW;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n  = 1'b1;
    logic          oe_n  = 1'b1;
    logic          we_n  = 1'b1;
    logic          lb_n  = 1'b1;
    logic          ub_n  = 1'b1;
    logic [AW-1:0] addr  = '0;
    logic [15:0]   din   = '0;
    logic [15:0]   dout;
    logic [1:0]    dout_en;

    int total = 0;
    int bad   = 0;
    logic [15:0] model [DEPTH];

    always #5 clk = ~clk;

    byte_lane_sram #(.ADDR_W(AW), .READ_LAT(RL)) i_byte_lane_sram (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [15:0] fill_pat(int a);
        return 16'(a * 40503) ^ 16'h5a5a;
    endfunction

    // Expected read word: disabled lanes read as zero (R9)
    function automatic logic [15:0] exp_word(logic [15:0] w, logic l, logic u);
        return {u ? 8'h00 : w[15:8], l ? 8'h00 : w[7:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
    endtask

    // One write edge; no lane may drive while write is decoded (R7)
    task automatic wr(logic [AW-1:0] a, logic [15:0] d, logic l, logic u,
                      logic oe, logic ce);
        @(negedge clk);
        ce_n = ce; we_n = 1'b0; oe_n = oe; lb_n = l; ub_n = u;
        addr = a; din = d;
        #1;
        if (!ce) check("R7", 32'(dout_en), 32'd0);
        @(posedge clk);
        if (!ce) begin
            if (!l) model[a][7:0]  = d[7:0];
            if (!u) model[a][15:8] = d[15:8];
        end
    endtask

    // Hold a read for RL edges, check latency, data and release
    task automatic rd(logic [AW-1:0] a, logic l, logic u, string req);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; lb_n = l; ub_n = u; addr = a;
        #1;
        check("R4", 32'(dout_en), 32'd0);
        for (int i = 0; i < RL; i++) begin
            @(posedge clk);
            #1;
            if (i < RL - 1) check("R4", 32'(dout_en), 32'd0);
        end
        check(req, 32'(dout_en), 32'({~u, ~l}));
        check(req, 32'(dout), 32'(exp_word(model[a], l, u)));
        @(negedge clk);
        oe_n = 1'b1;
        #1;
        check("R8", 32'(dout_en), 32'd0);
        check("R9", 32'(dout), 32'd0);
    endtask

    // Outputs-off: held for several edges, lanes never drive (R3)
    task automatic out_off(logic [AW-1:0] a);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; lb_n = 1'b0; ub_n = 1'b0; addr = a;
        for (int i = 0; i < RL + 1; i++) begin
            @(posedge clk);
            #1;
            check("R3", 32'(dout_en), 32'd0);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        // R10: reset edges with a read held keep outputs off
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; lb_n = 1'b0; ub_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1;
            check("R10", 32'(dout_en), 32'd0);
            check("R9", 32'(dout), 32'd0);
        end
        go_idle();
        rst_n = 1'b1;

        // R1: fill every word through both lanes
        for (int a = 0; a < DEPTH; a++) begin
            wr(AW'(a), fill_pat(a), 1'b0, 1'b0, 1'(a % 2), 1'b0);
        end
        go_idle();
        rd('0, 1'b0, 1'b0, "R1");
        rd(AW'(DEPTH - 1), 1'b0, 1'b0, "R1");
        rd(AW'(DEPTH / 2), 1'b0, 1'b0, "R1");

        // R5: single-lane reads map to the correct bits
        rd(AW'(3), 1'b0, 1'b1, "R5");
        rd(AW'(3), 1'b1, 1'b0, "R5");

        // R6: lower-only write with oe_n low, upper byte kept
        wr(AW'(5), 16'hbeef, 1'b0, 1'b1, 1'b0, 1'b0);
        go_idle();
        rd(AW'(5), 1'b0, 1'b0, "R6");
        wr(AW'(6), 16'hc0de, 1'b1, 1'b0, 1'b1, 1'b0);
        go_idle();
        rd(AW'(6), 1'b0, 1'b0, "R6");

        // R2: deselected write attempts leave the word unchanged
        wr(AW'(7), 16'h1111, 1'b0, 1'b0, 1'b0, 1'b1);
        wr(AW'(8), 16'h2222, 1'b1, 1'b1, 1'b0, 1'b0);
        go_idle();
        rd(AW'(7), 1'b0, 1'b0, "R2");
        rd(AW'(8), 1'b0, 1'b0, "R2");
        rd(AW'(9), 1'b1, 1'b1, "R2");
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; lb_n = 1'b0; ub_n = 1'b0;
        repeat (RL + 1) @(posedge clk);
        #1;
        check("R2", 32'(dout_en), 32'd0);

        // R3: outputs off, and no write while off
        out_off(AW'(10));
        go_idle();
        rd(AW'(10), 1'b0, 1'b0, "R3");

        // R10: reset mid-read drops output; a fresh read is needed after
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; lb_n = 1'b0; ub_n = 1'b0; addr = AW'(11);
        repeat (RL) @(posedge clk);
        #1;
        check("R4", 32'(dout_en), 32'd3);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R10", 32'(dout_en), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < RL; i++) begin
            @(posedge clk);
            #1;
            if (i < RL - 1) check("R10", 32'(dout_en), 32'd0);
        end
        check("R10", 32'(dout_en), 32'd3);
        check("R10", 32'(dout), 32'(model[11]));
        go_idle();

        // Random mix of writes, reads and outputs-off
        for (int n = 0; n < 600; n++) begin
            logic [AW-1:0] ra;
            int op;
            ra = AW'($urandom % DEPTH);
            op = int'($urandom % 4);
            if (op == 0) begin
                wr(ra, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   (($urandom % 8) == 0));
                go_idle();
            end else if (op == 3) begin
                out_off(ra);
                go_idle();
            end else begin
                rd(ra, 1'($urandom), 1'($urandom), "R6");
            end
        end

        go_idle();
        finish_run();
    end

endmodule